// File: doc/BRIEF.md
# Windowed Saturating Error Counter

This block measures link quality by totalling error events from a decoder pipeline. A control write sets three things: whether the window is fixed or unbounded, the window length, and which kind of error to total. The kinds are bit errors, byte errors and uncorrectable packets. The window advances one step for each data-valid strobe. The result is a 16-bit count that stops at its maximum value and does not wrap. A busy flag shows whether a measurement is in progress.

To measure, software writes the start bit as 1. This clears the count and latches the measurement settings. In fixed mode the block clears busy by itself once the programmed number of data-valid strobes has been seen. In unbounded mode, counting goes on until software writes the start bit as 0. The count then holds its value until the next start.

Top module: `esc_meter`

## Requirements
- R1: The count saturates at 0xFFFF: an increment that would pass it leaves the count at 0xFFFF, and the count never wraps.
- R2: A control write with start = 1 clears the count and the window progress and latches mode, window length and kind. Busy reads 1 from the next cycle. A start write during a running measurement restarts it with a zero count.
- R3: In fixed mode (ctl_inf = 0), busy is 0 in the cycle after the ctl_window-th data-valid strobe. Strobes after that point do not change the count.
- R4: In unbounded mode (ctl_inf = 1), busy stays 1 regardless of strobes. It clears in the cycle after a control write with start = 0.
- R5: The error kind is encoded in ctl_kind as 0 = bit errors (ev_bit_inc), 1 = byte errors (ev_byte_err), 2 = uncorrectable packets (ev_pkt_err), 3 = nothing counted.
- R6: A bit-error increment of 0 to 8 is added as given. A value above 8 is added as 8.
- R7: Error inputs are added only in cycles where ev_valid = 1, busy = 1 and no control write occurs. All other cycles leave the count unchanged.
- R8: After a measurement ends, the count holds its final value until the next start write.
- R9: In fixed mode with a window length of 0, busy is 1 for exactly one cycle and the count stays 0.
- R10: After reset, the count is 0 and busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_we | input | 1 | Control write strobe |
| ctl_start | input | 1 | Start bit value written with ctl_we |
| ctl_inf | input | 1 | 1 = unbounded window, 0 = fixed window |
| ctl_window | input | 16 | Fixed window length, in data-valid strobes |
| ctl_kind | input | 2 | Error kind select (R5) |
| ev_valid | input | 1 | Data-valid strobe; advances the window |
| ev_bit_inc | input | 4 | Bit errors in this data unit |
| ev_byte_err | input | 1 | Byte error in this data unit |
| ev_pkt_err | input | 1 | Uncorrectable packet in this data unit |
| meas_count | output | 16 | Saturating error count |
| meas_busy | output | 1 | Start/busy status |

## Verification
A wrong window counter shows at the ports when busy falls one strobe early or late. It also shows in a count that is off by one increment at the close of a fixed window. Both are visible in the cycle right after the last strobe. A kind-select or clamp fault alters the count on the first strobe. A saturation fault shows only after about 8200 strobes, so one vector drives the count past 0xFFFF and checks that it stays at the limit. Counting events after the end of a measurement, or in the start cycle, shows up as a drift in the held count. The directed tests read the count after such events.

// File: rtl/esc_pkg.sv
package esc_pkg;
    typedef enum logic [1:0] {
        KIND_BIT  = 2'd0,
        KIND_BYTE = 2'd1,
        KIND_PKT  = 2'd2,
        KIND_NONE = 2'd3
    } err_kind_e;

    localparam int unsigned BIT_INC_MAX = 8;
endpackage

// File: rtl/esc_inc_sel.sv
module esc_inc_sel
    import esc_pkg::*;
#(
    parameter int unsigned INC_W = 4
) (
    input  err_kind_e        kind,
    input  logic [INC_W-1:0] bit_inc,
    input  logic             byte_err,
    input  logic             pkt_err,
    output logic [INC_W-1:0] inc
);
    localparam logic [INC_W-1:0] CLAMP = INC_W'(BIT_INC_MAX);

    always_comb begin
        unique case (kind)
            KIND_BIT:  inc = (bit_inc > CLAMP) ? CLAMP : bit_inc;
            KIND_BYTE: inc = INC_W'(byte_err);
            KIND_PKT:  inc = INC_W'(pkt_err);
            default:   inc = '0;
        endcase
    end
endmodule

// File: rtl/esc_sat_add.sv
module esc_sat_add #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned INC_W = 4
) (
    input  logic [CNT_W-1:0] acc,
    input  logic [INC_W-1:0] inc,
    output logic [CNT_W-1:0] sum
);
    localparam logic [CNT_W:0] LIMIT = {1'b0, {CNT_W{1'b1}}};

    logic [CNT_W:0] wide;

    always_comb begin
        wide = {1'b0, acc} + (CNT_W+1)'(inc);
        sum  = (wide > LIMIT) ? {CNT_W{1'b1}} : wide[CNT_W-1:0];
    end
endmodule

// File: rtl/esc_win_track.sv
module esc_win_track #(
    parameter int unsigned WIN_W = 16
) (
    input  logic [WIN_W-1:0] win_cnt,
    input  logic [WIN_W-1:0] win_len,
    input  logic             step,
    output logic [WIN_W-1:0] cnt_next,
    output logic             done
);
    logic [WIN_W:0] bumped;

    always_comb begin
        bumped   = {1'b0, win_cnt} + 1'b1;
        cnt_next = step ? bumped[WIN_W-1:0] : win_cnt;
        done     = (win_len == '0) || (step && (bumped == {1'b0, win_len}));
    end
endmodule

// File: rtl/esc_meter.sv
module esc_meter
    import esc_pkg::*;
#(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned WIN_W = 16,
    parameter int unsigned INC_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we,
    input  logic             ctl_start,
    input  logic             ctl_inf,
    input  logic [WIN_W-1:0] ctl_window,
    input  logic [1:0]       ctl_kind,
    input  logic             ev_valid,
    input  logic [INC_W-1:0] ev_bit_inc,
    input  logic             ev_byte_err,
    input  logic             ev_pkt_err,
    output logic [CNT_W-1:0] meas_count,
    output logic             meas_busy
);
    typedef struct packed {
        logic             busy;
        logic             inf;
        err_kind_e        kind;
        logic [WIN_W-1:0] win_len;
        logic [WIN_W-1:0] win_cnt;
        logic [CNT_W-1:0] count;
    } meter_st_t;

    meter_st_t st_d, st_q;

    logic [INC_W-1:0] inc_w;
    logic [CNT_W-1:0] sum_w;
    logic [WIN_W-1:0] win_next_w;
    logic             win_done_w;
    logic             step_w;
    logic             mode_inf_q;

    assign step_w     = st_q.busy && !st_q.inf && ev_valid && !ctl_we;
    assign mode_inf_q = st_q.inf;

    esc_inc_sel #(.INC_W(INC_W)) inc_sel_i (
        .kind     (st_q.kind),
        .bit_inc  (ev_bit_inc),
        .byte_err (ev_byte_err),
        .pkt_err  (ev_pkt_err),
        .inc      (inc_w)
    );

    esc_sat_add #(.CNT_W(CNT_W), .INC_W(INC_W)) sat_add_i (
        .acc (st_q.count),
        .inc (inc_w),
        .sum (sum_w)
    );

    esc_win_track #(.WIN_W(WIN_W)) win_track_i (
        .win_cnt  (st_q.win_cnt),
        .win_len  (st_q.win_len),
        .step     (step_w),
        .cnt_next (win_next_w),
        .done     (win_done_w)
    );

    always_comb begin
        st_d = st_q;
        if (ctl_we) begin
            if (ctl_start) begin
                st_d.busy    = 1'b1;
                st_d.inf     = ctl_inf;
                st_d.kind    = err_kind_e'(ctl_kind);
                st_d.win_len = ctl_window;
                st_d.win_cnt = '0;
                st_d.count   = '0;
            end else begin
                st_d.busy = 1'b0;
            end
        end else if (st_q.busy) begin
            if (ev_valid) begin
                st_d.count = sum_w;
            end
            if (!st_q.inf) begin
                st_d.win_cnt = win_next_w;
                if (win_done_w) begin
                    st_d.busy = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, inf: 1'b0, kind: KIND_BIT,
                      win_len: '0, win_cnt: '0, count: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign meas_count = st_q.count;
    assign meas_busy  = st_q.busy;
endmodule

// File: rtl/esc_meter_chk.sv
module esc_meter_chk #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_we,
    input logic             ctl_start,
    input logic [CNT_W-1:0] meas_count,
    input logic             meas_busy,
    input logic             mode_inf_q
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && ctl_start |=> meas_busy && meas_count == '0); // R2

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we |=> meas_count >= $past(meas_count)); // R1

    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we && meas_count == TOP |=> meas_count == TOP); // R1

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_we && !meas_busy |=> $stable(meas_count) && !meas_busy); // R8

    AST_STOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_we && !ctl_start |=> !meas_busy); // R4

    AST_INF_NO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        meas_busy && mode_inf_q && !ctl_we |=> meas_busy); // R4
endmodule

bind esc_meter esc_meter_chk #(.CNT_W(CNT_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_we     (ctl_we),
    .ctl_start  (ctl_start),
    .meas_count (meas_count),
    .meas_busy  (meas_busy),
    .mode_inf_q (mode_inf_q)
);

// File: tb/esc_meter_tb.sv
`timescale 1ns/1ps
module esc_meter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0, ctl_start = 1'b0, ctl_inf = 1'b0;
    logic [15:0] ctl_window = '0;
    logic [1:0]  ctl_kind = '0;
    logic        ev_valid = 1'b0;
    logic [3:0]  ev_bit_inc = '0;
    logic        ev_byte_err = 1'b0, ev_pkt_err = 1'b0;
    logic [15:0] meas_count;
    logic        meas_busy;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    esc_meter dut_i (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_start(ctl_start),
        .ctl_inf(ctl_inf), .ctl_window(ctl_window), .ctl_kind(ctl_kind),
        .ev_valid(ev_valid), .ev_bit_inc(ev_bit_inc), .ev_byte_err(ev_byte_err),
        .ev_pkt_err(ev_pkt_err), .meas_count(meas_count), .meas_busy(meas_busy)
    );

    // {kind[1:0], window[15:0], strobes[15:0], bit_inc[3:0]}
    localparam int NV = 8;
    localparam logic [37:0] VEC [NV] = '{
        {2'd0, 16'd10,   16'd10,   4'd3},
        {2'd0, 16'd10,   16'd4,    4'd5},
        {2'd0, 16'd5,    16'd9,    4'd15},
        {2'd1, 16'd7,    16'd7,    4'd2},
        {2'd2, 16'd3,    16'd6,    4'd1},
        {2'd3, 16'd4,    16'd4,    4'd6},
        {2'd0, 16'd8200, 16'd8200, 4'd8},
        {2'd0, 16'd6,    16'd6,    4'd0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic ctl_write(input logic st, input logic inf, input logic [15:0] win, input logic [1:0] kind);
        @(negedge clk);
        ctl_we = 1'b1; ctl_start = st; ctl_inf = inf; ctl_window = win; ctl_kind = kind;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic strobes(input int n, input logic [3:0] bi, input logic vld);
        for (int i = 0; i < n; i++) begin
            ev_valid = vld; ev_bit_inc = bi; ev_byte_err = 1'b1; ev_pkt_err = 1'b1;
            @(negedge clk);
        end
        ev_valid = 1'b0; ev_bit_inc = '0; ev_byte_err = 1'b0; ev_pkt_err = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R10 count", 32'(meas_count), 0);
        check("R10 busy", 32'(meas_busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            logic [1:0]  k;
            logic [15:0] w, n;
            logic [3:0]  b;
            int used, per, exp;
            {k, w, n, b} = VEC[v];
            ctl_write(1'b1, 1'b0, w, k);
            strobes(int'(n), b, 1'b1);
            used = (n < w) ? int'(n) : int'(w);
            case (k)
                2'd0: per = (b > 4'd8) ? 8 : int'(b);
                2'd1, 2'd2: per = 1;
                default: per = 0;
            endcase
            exp = used * per;
            if (exp > 65535) exp = 65535;
            check("R1/R3/R5/R6 vector count", 32'(meas_count), 32'(exp));
            check("R3 vector busy", 32'(meas_busy), (n < w) ? 1 : 0);
        end

        // R3: strobes after a closed fixed window are ignored
        ctl_write(1'b1, 1'b0, 16'd4, 2'd1);
        strobes(4, 4'd0, 1'b1);
        strobes(5, 4'd0, 1'b1);
        check("R3 after window", 32'(meas_count), 4);

        // R4/R7/R8: unbounded mode
        ctl_write(1'b1, 1'b1, 16'd2, 2'd1);
        strobes(20, 4'd0, 1'b1);
        check("R4 inf busy", 32'(meas_busy), 1);
        check("R4 inf count", 32'(meas_count), 20);
        strobes(5, 4'd0, 1'b0);
        check("R7 no valid", 32'(meas_count), 20);
        ctl_write(1'b0, 1'b1, 16'd2, 2'd1);
        check("R4 stop busy", 32'(meas_busy), 0);
        strobes(6, 4'd0, 1'b1);
        check("R8 hold", 32'(meas_count), 20);

        // R9: zero window
        ctl_write(1'b1, 1'b0, 16'd0, 2'd0);
        check("R9 busy one cycle", 32'(meas_busy), 1);
        @(negedge clk);
        check("R9 busy cleared", 32'(meas_busy), 0);
        check("R9 count", 32'(meas_count), 0);

        // R2/R7: restart mid-run, events in the write cycle ignored
        ctl_write(1'b1, 1'b0, 16'd100, 2'd0);
        strobes(10, 4'd2, 1'b1);
        check("R2 before restart", 32'(meas_count), 20);
        @(negedge clk);
        ctl_we = 1'b1; ctl_start = 1'b1; ctl_inf = 1'b0; ctl_window = 16'd100; ctl_kind = 2'd0;
        ev_valid = 1'b1; ev_bit_inc = 4'd7;
        @(negedge clk);
        ctl_we = 1'b0; ev_valid = 1'b0; ev_bit_inc = '0;
        check("R2 restart clears", 32'(meas_count), 0);
        check("R2 restart busy", 32'(meas_busy), 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule